// File: doc/BRIEF.md
# Packed SIMD Lane ALU

This block is the arithmetic stage of a packed-SIMD datapath that works on ordinary integer registers of 32 or 64 bits. Each operand register is cut into independent lanes, and the lanes are processed side by side. The lane width and the signedness are not encoded in the opcode. They come from the bank that the destination register specifier falls into: one range of specifiers holds signed bytes, one unsigned bytes, one signed halfwords, one unsigned halfwords, and the top specifiers hold a full 32-bit word.

The operations are lane-wise add, subtract, equality compare, less-than compare, minimum and maximum. Less-than, minimum and maximum follow the signedness of the bank. Every lane that physically fits in the register is computed, whatever vector length software has set. A source specifier of zero names the hardwired zero register and reads as all zeros, whatever is on its data input. An operation is offered with a valid strobe, and its result appears with a matching valid strobe one clock later.

Top module: `simd_lane_alu`

## Requirements
- R1: The destination specifier `rd_spec` selects the lane layout. Values 0 to 7 select signed 8-bit lanes, 8 to 15 unsigned 8-bit lanes, 16 to 23 signed 16-bit lanes, 24 to 29 unsigned 16-bit lanes, and 30 to 31 signed 32-bit lanes. Every lane in the register is processed: XLEN/8, XLEN/16 or XLEN/32 lanes, with lane i occupying bits i*W to i*W+W-1.
- R2: `op` = 0 (add) gives each lane the sum modulo 2^W. No carry passes into the next lane.
- R3: `op` = 1 (subtract) gives each lane rs1 minus rs2 modulo 2^W. No borrow passes into the next lane.
- R4: `op` = 2 (equal) and `op` = 3 (less than, rs1 < rs2) set a lane to all ones when the condition is true and to all zeros when it is false.
- R5: `op` = 4 (minimum) and `op` = 5 (maximum) pick the smaller or larger lane value. The comparison for `op` 3, 4 and 5 is signed in signed banks and unsigned in unsigned banks.
- R6: A source specifier equal to 0 makes that operand read as zero, whatever its data input carries.
- R7: With `rd_spec` 30 or 31, each 32-bit word of the register is one signed lane: a single lane for XLEN=32, two for XLEN=64.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` was low, `result` keeps its previous value.
- R9: While `rst_n` is low, `out_valid` and `result` are 0.
- R10: `op` values 6 and 7 are reserved and give a result of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered this cycle |
| op | input | 3 | Lane operation code |
| rd_spec | input | 5 | Destination specifier; selects lane width and signedness |
| rs1_spec | input | 5 | First source specifier; 0 forces that operand to zero |
| rs2_spec | input | 5 | Second source specifier; 0 forces that operand to zero |
| rs1_data | input | XLEN | First operand register value |
| rs2_data | input | XLEN | Second operand register value |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Packed lane result |

## Verification
Every result is registered once, so it is due exactly one rising edge after the cycle in which it was offered. The bench drives each operation after a falling edge, waits for the next rising edge, and samples `out_valid` and `result` one time unit later. It compares them with a lane model computed in the bench from the bank ranges. Idle cycles are checked the same way: one edge after a cycle with `in_valid` low, `out_valid` must be low and `result` must be unchanged.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int SPEC_W = 5;

    // Bank boundaries in specifier space; decode order depends on them.
    localparam int BANK_U8_BASE  = 8;
    localparam int BANK_S16_BASE = 16;
    localparam int BANK_U16_BASE = 24;
    localparam int BANK_W32_BASE = 30;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_CMPEQ = 3'd2,
        OP_CMPLT = 3'd3,
        OP_MIN   = 3'd4,
        OP_MAX   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } lane_op_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2
    } elem_w_e;

    typedef struct packed {
        elem_w_e width;
        logic    is_signed;
    } bank_cfg_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/simd_bank_decode.sv
module simd_bank_decode
    import simd_alu_pkg::*;
(
    input  logic [SPEC_W-1:0] spec,
    output bank_cfg_t         cfg
);
    always_comb begin
        if (int'(spec) >= BANK_W32_BASE) begin
            cfg.width     = EW_32;
            cfg.is_signed = 1'b1;
        end else if (int'(spec) >= BANK_U16_BASE) begin
            cfg.width     = EW_16;
            cfg.is_signed = 1'b0;
        end else if (int'(spec) >= BANK_S16_BASE) begin
            cfg.width     = EW_16;
            cfg.is_signed = 1'b1;
        end else if (int'(spec) >= BANK_U8_BASE) begin
            cfg.width     = EW_8;
            cfg.is_signed = 1'b0;
        end else begin
            cfg.width     = EW_8;
            cfg.is_signed = 1'b1;
        end
    end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_op_e     op,
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);
    logic signed [W:0] a_ext;
    logic signed [W:0] b_ext;
    logic              a_lt_b;
    logic              a_eq_b;

    // One extra bit turns both signed and unsigned order into a signed compare.
    assign a_ext  = {sgn & a[W-1], a};
    assign b_ext  = {sgn & b[W-1], b};
    assign a_lt_b = (a_ext < b_ext);
    assign a_eq_b = (a == b);

    always_comb begin
        unique case (op)
            OP_ADD:   r = a + b;
            OP_SUB:   r = a - b;
            OP_CMPEQ: r = {W{a_eq_b}};
            OP_CMPLT: r = {W{a_lt_b}};
            OP_MIN:   r = a_lt_b ? a : b;
            OP_MAX:   r = a_lt_b ? b : a;
            default:  r = '0;
        endcase
    end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
    import simd_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int W    = 8
) (
    input  lane_op_e        op,
    input  logic            sgn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] r
);
    localparam int LANES = XLEN / W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_lane #(.W(W)) u_lane (
            .op  (op),
            .sgn (sgn),
            .a   (a[i*W +: W]),
            .b   (b[i*W +: W]),
            .r   (r[i*W +: W])
        );
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      op,
    input  logic [4:0]      rd_spec,
    input  logic [4:0]      rs1_spec,
    input  logic [4:0]      rs2_spec,
    input  logic [XLEN-1:0] rs1_data,
    input  logic [XLEN-1:0] rs2_data,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    bank_cfg_t       cfg;
    lane_op_e        op_e;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] res8;
    logic [XLEN-1:0] res16;
    logic [XLEN-1:0] res32;
    logic [XLEN-1:0] res_sel;
    out_state_e      state_q;
    out_state_e      state_d;

    assign op_e = lane_op_e'(op);

    simd_bank_decode u_decode (
        .spec (rd_spec),
        .cfg  (cfg)
    );

    // The zero register ignores its data input.
    assign opa = (rs1_spec == '0) ? '0 : rs1_data;
    assign opb = (rs2_spec == '0) ? '0 : rs2_data;

    simd_lane_array #(.XLEN(XLEN), .W(8)) u_arr8 (
        .op (op_e), .sgn (cfg.is_signed), .a (opa), .b (opb), .r (res8)
    );
    simd_lane_array #(.XLEN(XLEN), .W(16)) u_arr16 (
        .op (op_e), .sgn (cfg.is_signed), .a (opa), .b (opb), .r (res16)
    );
    simd_lane_array #(.XLEN(XLEN), .W(32)) u_arr32 (
        .op (op_e), .sgn (cfg.is_signed), .a (opa), .b (opb), .r (res32)
    );

    always_comb begin
        unique case (cfg.width)
            EW_8:    res_sel = res8;
            EW_16:   res_sel = res16;
            default: res_sel = res32;
        endcase
    end

    // Output stage: ACCEPT (EMPTY->FULL), STREAM (FULL->FULL), DRAIN (FULL->EMPTY).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= res_sel;
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/simd_lane_alu_checker.sv
module simd_lane_alu_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      op,
    input logic [4:0]      rd_spec,
    input logic [4:0]      rs1_spec,
    input logic [4:0]      rs2_spec,
    input logic [XLEN-1:0] rs1_data,
    input logic [XLEN-1:0] rs2_data,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    // R8: a valid input yields a valid output one edge later
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: an idle cycle yields no output and leaves the result unchanged
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R2, R6: adding the zero register returns the other operand in every layout
    a_r2_add_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0 && rs2_spec == 5'd0)
        |=> result == $past((rs1_spec == 5'd0) ? '0 : rs1_data));

    // R4: equal non-zero sources compare true in every lane
    a_r4_eq_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2 && rs1_spec != 5'd0 && rs2_spec != 5'd0
         && rs1_data == rs2_data) |=> result == '1);

    // R7: zero is below one in each signed 32-bit lane
    a_r7_word_lane_lt: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3 && rd_spec >= 5'd30 && rs1_spec == 5'd0
         && rs2_spec != 5'd0 && rs2_data == {(XLEN/32){32'h0000_0001}})
        |=> result == '1);

    // R10: reserved codes clear the result
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b11) |=> result == '0);

    // R9: the cycle after reset is asserted, the outputs are cleared
    a_r9_reset_clears: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && result == '0));
endmodule

bind simd_lane_alu simd_lane_alu_checker #(.XLEN(XLEN)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .rd_spec   (rd_spec),
    .rs1_spec  (rs1_spec),
    .rs2_spec  (rs2_spec),
    .rs1_data  (rs1_data),
    .rs2_data  (rs2_data),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/simd_lane_alu_bench.sv
`timescale 1ns/1ps
module simd_lane_alu_bench;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [2:0]      op = '0;
    logic [4:0]      rd_spec = '0;
    logic [4:0]      rs1_spec = '0;
    logic [4:0]      rs2_spec = '0;
    logic [XLEN-1:0] rs1_data = '0;
    logic [XLEN-1:0] rs2_data = '0;
    logic            out_valid;
    logic [XLEN-1:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [XLEN-1:0] last_res = '0;

    always #2 clk = ~clk;

    simd_lane_alu #(.XLEN(XLEN)) u_simd_lane_alu (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op (op),
        .rd_spec (rd_spec), .rs1_spec (rs1_spec), .rs2_spec (rs2_spec),
        .rs1_data (rs1_data), .rs2_data (rs2_data),
        .out_valid (out_valid), .result (result)
    );

    // Lane model derived from the bank ranges of R1..R10.
    function automatic logic [XLEN-1:0] model(input logic [2:0] o, input logic [4:0] rd,
            input logic [4:0] s1, input logic [4:0] s2,
            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        int w;
        bit sg;
        logic [XLEN-1:0] aa, bb, r;
        logic [63:0] ua, ub, mask, mv;
        longint x, y, m;
        w  = (rd < 16) ? 8 : ((rd < 30) ? 16 : 32);
        sg = (rd < 8) || (rd >= 16 && rd < 24) || (rd >= 30);
        aa = (s1 == 0) ? '0 : a;
        bb = (s2 == 0) ? '0 : b;
        mask = (64'd1 << w) - 64'd1;
        r = '0;
        for (int i = 0; i < XLEN / w; i++) begin
            ua = (64'(aa) >> (i * w)) & mask;
            ub = (64'(bb) >> (i * w)) & mask;
            x = (sg && ua[w-1]) ? longint'(ua) - (longint'(1) << w) : longint'(ua);
            y = (sg && ub[w-1]) ? longint'(ub) - (longint'(1) << w) : longint'(ub);
            case (o)
                3'd0: m = x + y;
                3'd1: m = x - y;
                3'd2: m = (x == y) ? -1 : 0;
                3'd3: m = (x < y) ? -1 : 0;
                3'd4: m = (x < y) ? x : y;
                3'd5: m = (x < y) ? y : x;
                default: m = 0;
            endcase
            mv = 64'(m) & mask;
            r = r | XLEN'(mv << (i * w));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one operation, sample one edge later.
    task automatic run(input string req, input logic [2:0] o, input logic [4:0] rd,
            input logic [4:0] s1, input logic [4:0] s2,
            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        logic [XLEN-1:0] exp;
        @(negedge clk);
        in_valid = 1'b1; op = o; rd_spec = rd; rs1_spec = s1; rs2_spec = s2;
        rs1_data = a; rs2_data = b;
        exp = model(o, rd, s1, s2, a, b);
        @(posedge clk); #1;
        check({req, " R8 valid"}, XLEN'(out_valid), XLEN'(1));
        check(req, result, exp);
        last_res = result;
    endtask

    task automatic idle(input logic [XLEN-1:0] junk);
        @(negedge clk);
        in_valid = 1'b0; op = 3'd0; rd_spec = 5'd9; rs1_spec = 5'd3; rs2_spec = 5'd4;
        rs1_data = junk; rs2_data = ~junk;
        @(posedge clk); #1;
        check("R8 idle valid", XLEN'(out_valid), '0);
        check("R8 idle hold", result, last_res);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired got %0d expected finish", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rs1_data = 32'hDEAD_BEEF;
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset valid", XLEN'(out_valid), '0);
        check("R9 reset result", result, '0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;

        // R2: carry must stop at each byte and halfword boundary
        run("R2 add u8 wrap", 3'd0, 5'd9, 5'd1, 5'd2, 32'hFF80_01FF, 32'h0180_FF01);
        check("R2 add u8 literal", result, 32'h0000_0000);
        run("R2 add s16 wrap", 3'd0, 5'd17, 5'd1, 5'd2, 32'hFFFF_7FFF, 32'h0001_0001);
        check("R2 add s16 literal", result, 32'h0000_8000);
        // R3: borrow must not cross lanes
        run("R3 sub u8", 3'd1, 5'd10, 5'd1, 5'd2, 32'h0001_0203, 32'h0102_0304);
        check("R3 sub literal", result, 32'hFFFF_FFFF);
        // R4: compares
        run("R4 eq mixed", 3'd2, 5'd3, 5'd1, 5'd2, 32'h1122_3344, 32'h1100_3300);
        check("R4 eq literal", result, 32'hFF00_FF00);
        run("R4 lt s8", 3'd3, 5'd2, 5'd1, 5'd2, 32'h80_7F_00_01, 32'h00_00_01_01);
        check("R4 lt literal", result, 32'hFF_00_FF_00);
        // R5: signedness from bank
        run("R5 min s8", 3'd4, 5'd4, 5'd1, 5'd2, 32'h8000_7F01, 32'h0180_0102);
        run("R5 min u8", 3'd4, 5'd12, 5'd1, 5'd2, 32'h8000_7F01, 32'h0180_0102);
        run("R5 max s16", 3'd5, 5'd20, 5'd1, 5'd2, 32'h8000_0001, 32'h7FFF_FFFF);
        check("R5 max s16 literal", result, 32'h7FFF_0001);
        run("R5 max u16", 3'd5, 5'd26, 5'd1, 5'd2, 32'h8000_0001, 32'h7FFF_FFFF);
        check("R5 max u16 literal", result, 32'h8000_FFFF);
        // R6: zero register ignores data
        run("R6 zero src", 3'd0, 5'd9, 5'd0, 5'd0, 32'h1234_5678, 32'h9ABC_DEF0);
        check("R6 zero literal", result, '0);
        run("R6 zero rs1 sub", 3'd1, 5'd25, 5'd0, 5'd5, 32'hFFFF_FFFF, 32'h0001_0002);
        // R7: word lane, carry crosses bytes inside a word
        run("R7 add word", 3'd0, 5'd30, 5'd1, 5'd2, 32'h0000_FFFF, 32'h0000_0001);
        check("R7 add literal", result, 32'h0001_0000);
        run("R7 lt signed word", 3'd3, 5'd31, 5'd1, 5'd2, 32'h8000_0000, 32'h0000_0001);
        check("R7 lt literal", result, 32'hFFFF_FFFF);
        // R10: reserved codes
        run("R10 rsv6", 3'd6, 5'd1, 5'd1, 5'd2, 32'h1111_1111, 32'h2222_2222);
        run("R10 rsv7", 3'd7, 5'd31, 5'd1, 5'd2, 32'h1111_1111, 32'h2222_2222);
        // R8: idle cycles
        idle(32'hA5A5_A5A5);
        idle(32'h0F0F_F0F0);

        // R1: random across every bank and op
        for (int n = 0; n < 400; n++) begin
            logic [2:0] ro;
            logic [4:0] rd, s1, s2;
            ro = 3'($urandom_range(0, 7));
            rd = 5'($urandom_range(0, 31));
            s1 = 5'($urandom_range(0, 7));
            s2 = 5'($urandom_range(0, 7));
            run("R1 random", ro, rd, s1, s2, $urandom(), $urandom());
            if ($urandom_range(0, 5) == 0) idle($urandom());
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule